// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises characters onto an asynchronous line. A character written by software lands in a one-entry holding buffer; as soon as the shift engine is free and transmission is enabled, the character moves into the shifter. The shifter then sends a low start bit, the data bits with bit 0 first, an optional parity bit and one or two high stop bits. Because the buffer is refilled while the shifter is busy, a program that keeps the buffer topped up gets frames with no gap between them.

The bit time comes from a built-in divider that counts pulses of a selectable count source: the system clock divided by 1, 8 or 32, or the rising edges of an external clock pin after synchronisation. Two status flags report an empty holding buffer and a fully drained transmitter. One sticky interrupt request can be tied either to the buffer emptying or to the end of transmission, and it stays set until acknowledged.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: Each bit lasts 16*(`div_n`+1) pulses of the count source picked by `clk_sel`: 0 = every system clock, 1 = every 8th clock, 2 = every 32nd clock, 3 = each rising edge of `ext_clk` seen through a two-flop synchronizer. The first bit of a frame that starts from idle lasts the full count.
- R3: A frame is one 0 start bit, then the data bits with `wr_data[0]` first (8 bits when `nine_bit`=0, 9 bits including `wr_data[8]` when `nine_bit`=1), then a parity bit when `par_en`=1, then one stop bit of value 1 (`two_stop`=0) or two (`two_stop`=1). The settings in force when the character enters the shifter govern the whole frame.
- R4: The parity bit is the XOR of the sent data bits when `par_odd`=0, and the inverse of that XOR when `par_odd`=1.
- R5: A `wr_valid` pulse stores `wr_data` in the holding buffer and clears `buf_empty` from the next cycle. When the shifter is idle and enabled, the character enters the shifter on the following clock edge, `buf_empty` returns to 1 and the start bit appears on `txd` from that edge. A write to a full buffer replaces the waiting character.
- R6: If a character is waiting when the last stop bit ends, its start bit begins on the same edge, with no idle time between the two frames.
- R7: Clearing `tx_en` lets the frame in progress finish; no new frame starts while `tx_en` is 0, a waiting character stays in the buffer, and `txd` holds 1. Setting `tx_en` again sends the waiting character.
- R8: `shift_empty` is 1 only when both the shifter and the holding buffer are empty; it rises on the edge that ends the last stop bit of the final frame.
- R9: With `irq_on_done`=0, `irq` is set when a character moves from the buffer into the shifter; with `irq_on_done`=1, it is set when the last stop bit ends with the buffer empty. Once set, `irq` stays 1 until a cycle with `irq_ack`=1 (a new event in that same cycle keeps it set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | 1 appends a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| div_n | input | 8 | Divider value n; bit time is 16*(n+1) source pulses |
| clk_sel | input | 2 | Count source: 0 div1, 1 div8, 2 div32, 3 external |
| ext_clk | input | 1 | External count clock, asynchronous |
| wr_valid | input | 1 | One-cycle write strobe for the holding buffer |
| wr_data | input | 9 | Character to send |
| irq_on_done | input | 1 | Interrupt trigger: 0 buffer empty, 1 transmission complete |
| irq_ack | input | 1 | Clears the pending interrupt |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer has no character |
| shift_empty | output | 1 | Buffer and shifter both empty |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is a disable that lands in the middle of a frame while a second character already sits in the holding buffer. The only way to reach it from the ports is to write the first character into an idle transmitter, write the second while the first is still shifting out, and then drop `tx_en` partway through the first frame. The bench then watches the line stay at mark for several bit times with `buf_empty` and `shift_empty` both low before it re-enables. Back-to-back frames are checked by measuring the distance between consecutive start edges against the bench's own frame length times the bit time.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FRAME_W  = 13;  // start + 9 data + parity + 2 stop
  localparam int FLEN_W   = 4;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_e;

  // parity over the bits actually sent
  function automatic logic parity_of(input logic [8:0] d, input logic nine,
                                     input logic odd);
    logic [8:0] m;
    m = nine ? d : {1'b0, d[7:0]};
    return (^m) ^ odd;
  endfunction

  function automatic logic [FLEN_W-1:0] frame_len(input logic nine,
                                                  input logic par,
                                                  input logic two);
    logic [FLEN_W-1:0] n;
    n = 4'd1 + (nine ? 4'd9 : 4'd8) + {3'b000, par} + (two ? 4'd2 : 4'd1);
    return n;
  endfunction

  // bit 0 goes out first; unused upper positions stay 1 (stop/mark)
  function automatic logic [FRAME_W-1:0] build_frame(input logic [8:0] d,
                                                     input logic nine,
                                                     input logic par,
                                                     input logic odd);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i < 8 || nine) f[1+i] = d[i];
    end
    if (par) begin
      if (nine) f[10] = parity_of(d, nine, odd);
      else      f[9]  = parity_of(d, nine, odd);
    end
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
  import uart_tx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             ext_clk,
  input  logic             run,
  input  logic             restart,
  output logic             src_pulse,
  output logic             bit_tick
);
  localparam int CNT_W = DIV_W + 4;

  logic [PRE_W-1:0]       pre_cnt;
  logic [SYNC_STAGES:0]   sync_q;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       limit;
  logic                   ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  // synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= ext_clk;
  end

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_DIV1:  src_pulse = 1'b1;
      SRC_DIV8:  src_pulse = &pre_cnt[2:0];
      SRC_DIV32: src_pulse = &pre_cnt[4:0];
      default:   src_pulse = ext_rise;
    endcase
  end

  assign limit    = {div_n, 4'hF};
  assign bit_tick = run & src_pulse & (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (run && src_pulse) cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_valid) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [8:0] load_data,
  input  logic       nine_bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       bit_tick,
  output logic       busy,
  output logic       frame_end,
  output logic       txd
);
  logic [FRAME_W-1:0] frame_q;
  logic [FLEN_W-1:0]  len_q;
  logic [FLEN_W-1:0]  idx_q;
  logic               last_bit;

  assign last_bit  = (idx_q == len_q - 1'b1);
  assign frame_end = busy & bit_tick & last_bit;
  assign txd       = busy ? frame_q[idx_q] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      len_q   <= '0;
      idx_q   <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      frame_q <= build_frame(load_data, nine_bit, par_en, par_odd);
      len_q   <= frame_len(nine_bit, par_en, two_stop);
      idx_q   <= '0;
    end else if (frame_end) begin
      busy    <= 1'b0;
      idx_q   <= '0;
    end else if (busy && bit_tick) begin
      idx_q   <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             nine_bit,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] div_n,
  input  logic [1:0]       clk_sel,
  input  logic             ext_clk,
  input  logic             wr_valid,
  input  logic [8:0]       wr_data,
  input  logic             irq_on_done,
  input  logic             irq_ack,
  output logic             txd,
  output logic             buf_empty,
  output logic             shift_empty,
  output logic             irq
);
  logic       buf_full;
  logic [8:0] buf_data;
  logic       busy;
  logic       frame_end;
  logic       bit_tick;
  logic       src_pulse;
  logic       load_evt;
  logic       done_evt;
  logic       irq_evt;

  // a character enters the shifter when idle or on the last tick of a frame
  assign load_evt = buf_full & tx_en & (~busy | frame_end);
  assign done_evt = frame_end & ~buf_full;
  assign irq_evt  = irq_on_done ? done_evt : load_evt;

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (clk_sel),
    .div_n     (div_n),
    .ext_clk   (ext_clk),
    .run       (busy),
    .restart   (load_evt),
    .src_pulse (src_pulse),
    .bit_tick  (bit_tick)
  );

  uart_tx_hold #(.DATA_W(9)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (load_evt),
    .full     (buf_full),
    .data     (buf_data)
  );

  uart_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_data (buf_data),
    .nine_bit  (nine_bit),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .two_stop  (two_stop),
    .bit_tick  (bit_tick),
    .busy      (busy),
    .frame_end (frame_end),
    .txd       (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_evt) irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end

  assign buf_empty   = ~buf_full;
  assign shift_empty = ~buf_full & ~busy;

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_valid,
  input logic irq_ack,
  input logic txd,
  input logic buf_empty,
  input logic shift_empty,
  input logic irq,
  input logic busy,
  input logic load_evt,
  input logic frame_end,
  input logic bit_tick
);
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);                                              // R7
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (busy && !txd));                                // R3
  AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> tx_en);                                         // R7
  AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> buf_empty);                                  // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);                                  // R9
  AST_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> busy);                                          // R2
  AST_BUF_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_valid) |=> buf_empty);                      // R5
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !buf_empty && tx_en) |=> (busy && !txd));      // R6
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .wr_valid    (wr_valid),
  .irq_ack     (irq_ack),
  .txd         (txd),
  .buf_empty   (buf_empty),
  .shift_empty (shift_empty),
  .irq         (irq),
  .busy        (busy),
  .load_evt    (load_evt),
  .frame_end   (frame_end),
  .bit_tick    (bit_tick)
);

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic       nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic [7:0] div_n = 8'd0;
  logic [1:0] clk_sel = 2'd0;
  logic       ext_clk = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       irq_on_done = 1'b0, irq_ack = 1'b0;
  logic       txd, buf_empty, shift_empty, irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [12:0] bits;
    int          len;
    int          m;
    bit          b2b;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_bit(nine_bit),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .div_n(div_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
    .wr_valid(wr_valid), .wr_data(wr_data), .irq_on_done(irq_on_done),
    .irq_ack(irq_ack), .txd(txd), .buf_empty(buf_empty),
    .shift_empty(shift_empty), .irq(irq)
  );

  // external count clock: one rising edge every 4 system cycles
  initial forever begin
    repeat (2) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int src_mult();
    case (clk_sel)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 32;
      default: return 4;
    endcase
  endfunction

  // expected frame from the requirements (R3, R4, R2)
  function automatic item_t expect_frame(input logic [8:0] d, input bit b2b);
    item_t it;
    int    p;
    int    ones;
    it.bits = '1;
    it.bits[0] = 1'b0;
    p = 1;
    ones = 0;
    for (int i = 0; i < (nine_bit ? 9 : 8); i++) begin
      it.bits[p] = d[i];
      ones += d[i];
      p++;
    end
    if (par_en) begin
      it.bits[p] = (ones % 2 == 1) ? ~par_odd : par_odd;
      p++;
    end
    it.len = p + (two_stop ? 2 : 1);
    it.m   = 16 * (int'(div_n) + 1) * src_mult();
    it.b2b = b2b;
    return it;
  endfunction

  task automatic raw_write(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input bit b2b);
    while (!buf_empty) @(negedge clk);
    exp_q.push_back(expect_frame(d, b2b));
    raw_write(d);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !shift_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // monitor: detects start edges and compares each bit at its middle
  initial begin
    int prev_start = 0;
    int prev_span  = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !txd) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected start", 32'd1, 32'd0);
          @(negedge clk);
        end else begin
          item_t it;
          int    st;
          it = exp_q.pop_front();
          st = cyc;
          if (it.b2b) chk("R6 start spacing", st - prev_start, prev_span);
          repeat (it.m / 2) @(negedge clk);
          for (int i = 0; i < it.len; i++) begin
            chk($sformatf("R3 bit %0d", i), txd, it.bits[i]);
            if (i < it.len - 1) repeat (it.m) @(negedge clk);
          end
          prev_start = st;
          prev_span  = it.len * it.m;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk("watchdog", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1'b1);
    chk("R1 buf_empty", buf_empty, 1'b1);
    chk("R1 shift_empty", shift_empty, 1'b1);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // 8N1, n=0, div1: exact buffer, drain and interrupt timing
    exp_q.push_back(expect_frame(9'h0A5, 0));
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 9'h0A5;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R5 buf_empty after write", buf_empty, 1'b0);
    @(negedge clk);
    chk("R5 buf_empty after load", buf_empty, 1'b1);
    chk("R9 irq on buffer empty", irq, 1'b1);
    chk("R8 shift_empty during frame", shift_empty, 1'b0);
    chk("R5 start bit", txd, 1'b0);
    repeat (15) @(negedge clk);
    chk("R2 first bit full length", txd, 1'b0);
    repeat (144) @(negedge clk);
    chk("R8 shift_empty before last edge", shift_empty, 1'b0);
    @(negedge clk);
    chk("R8 shift_empty after stop", shift_empty, 1'b1);
    ack();
    chk("R9 irq cleared by ack", irq, 1'b0);
    drain();

    // even parity, n=1, back to back
    par_en = 1'b1; par_odd = 1'b0; div_n = 8'd1;
    send(9'h03C, 0);
    send(9'h001, 1);
    drain();

    // odd parity, 9-bit
    nine_bit = 1'b1; par_odd = 1'b1; div_n = 8'd0;
    send(9'h1F3, 0);
    send(9'h100, 1);
    drain();

    // 9-bit, no parity, two stop bits, back to back (R6)
    par_en = 1'b0; two_stop = 1'b1;
    send(9'h155, 0);
    send(9'h0AA, 1);
    drain();

    // interrupt on transmission complete (R9)
    nine_bit = 1'b0; two_stop = 1'b0;
    irq_on_done = 1'b1;
    ack();
    send(9'h066, 0);
    repeat (40) @(negedge clk);
    chk("R9 irq low mid frame", irq, 1'b0);
    while (!shift_empty) @(negedge clk);
    chk("R9 irq set at completion", irq, 1'b1);
    ack();
    chk("R9 irq cleared", irq, 1'b0);
    drain();
    irq_on_done = 1'b0;

    // disable mid-frame with a character waiting (R7)
    send(9'h0C3, 0);
    send(9'h03A, 0);
    repeat (50) @(negedge clk);
    tx_en = 1'b0;
    repeat (200) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R7 line mark while disabled", txd, 1'b1);
      chk("R7 char held", buf_empty, 1'b0);
      repeat (16) @(negedge clk);
    end
    chk("R8 shift_empty with char waiting", shift_empty, 1'b0);
    tx_en = 1'b1;
    drain();

    // overwrite of a waiting character (R5)
    tx_en = 1'b0;
    raw_write(9'h011);
    raw_write(9'h0EE);
    chk("R5 buffer full", buf_empty, 1'b0);
    exp_q.push_back(expect_frame(9'h0EE, 0));
    tx_en = 1'b1;
    drain();

    // prescaled and external count sources (R2)
    clk_sel = 2'd1;
    send(9'h05A, 0);
    drain();
    clk_sel = 2'd2;
    send(9'h0B1, 0);
    drain();
    clk_sel = 2'd3;
    send(9'h0E7, 0);
    send(9'h018, 0);
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule